// File: doc/BRIEF.md
# Narrow-to-wide registered bus exchanger

The block links a narrow port with a pair of wide-side ports that share one clock. In the narrow-to-wide direction, two narrow words arrive one after the other. The first is parked in a front register. When the second arrives, both move out together, so the wide side sees them side by side as one double-width word. The upper half is the second word, on port 2B, and the lower half is the first word, on port 1B. Because of this, the 1B path is two registers deep and the 2B path is one register deep.

In the wide-to-narrow direction, each wide-side word is caught in its own register. A select input then picks, without a clock, which held word the narrow port presents. Every storage element loads on the rising clock edge, and only while its active-low load enable is low.

Each direction also has an active-low output enable. The block samples it on the clock and presents it as an active-high drive flag next to the data outputs, so that the bus turns around in step with the clock. A synchronous active-high reset clears all data and turns both drive flags off.

Top module: `xchg_narrow_wide`

## Requirements
- R1: While `rst` is high at a rising edge, every data register clears to zero. Both `a_drive` and `b_drive` go to 0 after that edge.
- R2: The 1B front register takes `a_in` on an edge where `ld_a1_n` is 0 and keeps its value when `ld_a1_n` is 1. A word loaded there reaches `b1_out` only on a later edge, so it needs two edges in total.
- R3: `b1_out` takes the 1B front register's value on an edge where `ld_a2_n` is 0 and holds when `ld_a2_n` is 1.
- R4: `b2_out` takes `a_in` on an edge where `ld_a2_n` is 0 and holds when `ld_a2_n` is 1.
- R5: Word X is presented on an edge with `ld_a1_n`=0 and `ld_a2_n`=1. Word Y is presented on the next edge with `ld_a1_n`=1 and `ld_a2_n`=0. After that second edge, `b1_out`=X and `b2_out`=Y, which is the wide word {Y,X}.
- R6: The 1B-side capture register takes `b1_in` when `ld_b1_n` is 0. The 2B-side capture register takes `b2_in` when `ld_b2_n` is 0. Each register holds while its enable is 1, and the two are independent.
- R7: `a_out` shows the 1B-side capture register when `sel` is 1 and the 2B-side capture register when `sel` is 0. A change of `sel` takes effect with no clock edge.
- R8: `a_drive` and `b_drive` equal the inverse of `oe_a_n` and `oe_b_n` as sampled at the most recent rising edge. A change of an enable between edges does not change its flag.
- R9: The two drive flags are independent. Both enables at 1 leave both ports undriven, both at 0 drive both ports, and mixed values drive only the port whose enable is 0.
- R10: On an edge where `ld_a1_n` and `ld_a2_n` are both 0, the 1B front register takes `a_in` and `b1_out` takes the front register's old value, both in the same edge. `b2_out` also takes `a_in` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | NARROW_W | Narrow-port data toward the wide side |
| ld_a1_n | input | 1 | Load enable of the 1B front register, active low |
| ld_a2_n | input | 1 | Load enable of the 1B rear register and the 2B register, active low |
| b1_in | input | NARROW_W | 1B-side data toward the narrow port |
| b2_in | input | NARROW_W | 2B-side data toward the narrow port |
| ld_b1_n | input | 1 | Load enable of the 1B-side capture register, active low |
| ld_b2_n | input | 1 | Load enable of the 2B-side capture register, active low |
| sel | input | 1 | 1 picks the 1B-side word for `a_out`, 0 picks the 2B-side word |
| oe_a_n | input | 1 | Narrow-port output enable, active low, sampled on the clock |
| oe_b_n | input | 1 | Wide-port output enable, active low, sampled on the clock |
| a_out | output | NARROW_W | Narrow-port output data |
| a_drive | output | 1 | Narrow port is driving |
| b1_out | output | NARROW_W | 1B output data, lower half of the wide word |
| b2_out | output | NARROW_W | 2B output data, upper half of the wide word |
| b_drive | output | 1 | Wide port is driving |

## Verification
The two functions that can fall on the same edge are the front-register capture and the transfer from the front register into `b1_out`. The bench provokes this overlap by holding both narrow-side load enables low for two edges in a row, each time with a new word on `a_in`. It judges the result by requiring that `b1_out` carries the previous front word, not the word just presented, while `b2_out` carries the new word. A plain two-word gather and a hold-all step are run before and after this overlap, so that a design which swaps the update order, or lets the new word pass straight through, gives a mismatch.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  // Registered drive state of the two ports, active high.
  typedef struct packed {
    logic a_on;
    logic b_on;
  } drive_t;

  localparam drive_t DRIVE_OFF = '{a_on: 1'b0, b_on: 1'b0};
endpackage

// File: rtl/xchg_en_reg.sv
module xchg_en_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (!ld_n) q <= d;
  end
endmodule

// File: rtl/xchg_a2b_path.sv
module xchg_a2b_path #(
  parameter int NARROW_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NARROW_W-1:0] a_in,
  input  logic                ld_a1_n,
  input  logic                ld_a2_n,
  output logic [NARROW_W-1:0] b1_out,
  output logic [NARROW_W-1:0] b2_out
);
  logic [NARROW_W-1:0] front_q;

  // Front stage of the deep path: captures the first word.
  xchg_en_reg #(.W(NARROW_W)) u_front (
    .clk(clk), .rst(rst), .ld_n(ld_a1_n), .d(a_in), .q(front_q)
  );
  // Rear stage of the deep path and the shallow path share the second enable.
  xchg_en_reg #(.W(NARROW_W)) u_rear (
    .clk(clk), .rst(rst), .ld_n(ld_a2_n), .d(front_q), .q(b1_out)
  );
  xchg_en_reg #(.W(NARROW_W)) u_shallow (
    .clk(clk), .rst(rst), .ld_n(ld_a2_n), .d(a_in), .q(b2_out)
  );

  p_front_load_r2: assert property (@(posedge clk) disable iff (rst)
    !ld_a1_n |=> front_q == $past(a_in));
  p_front_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ld_a1_n |=> $stable(front_q));
  p_rear_step_r3: assert property (@(posedge clk) disable iff (rst)
    !ld_a2_n |=> b1_out == $past(front_q));
  p_rear_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ld_a2_n |=> $stable(b1_out));
  p_shallow_load_r4: assert property (@(posedge clk) disable iff (rst)
    !ld_a2_n |=> b2_out == $past(a_in));
  p_pair_align_r5: assert property (@(posedge clk) disable iff (rst)
    (!ld_a1_n && ld_a2_n) ##1 (ld_a1_n && !ld_a2_n)
      |=> (b1_out == $past(a_in, 2)) && (b2_out == $past(a_in)));
  p_overlap_r10: assert property (@(posedge clk) disable iff (rst)
    (!ld_a1_n && !ld_a2_n)
      |=> (front_q == $past(a_in)) && (b1_out == $past(front_q)));
endmodule

// File: rtl/xchg_b2a_path.sv
module xchg_b2a_path #(
  parameter int NARROW_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NARROW_W-1:0] b1_in,
  input  logic [NARROW_W-1:0] b2_in,
  input  logic                ld_b1_n,
  input  logic                ld_b2_n,
  input  logic                sel,
  output logic [NARROW_W-1:0] a_out
);
  localparam int NSRC = 2;

  logic [NARROW_W-1:0] cap_d  [NSRC];
  logic [NARROW_W-1:0] cap_q  [NSRC];
  logic                cap_ld [NSRC];

  assign cap_d[0]  = b1_in;
  assign cap_d[1]  = b2_in;
  assign cap_ld[0] = ld_b1_n;
  assign cap_ld[1] = ld_b2_n;

  for (genvar i = 0; i < NSRC; i++) begin : g_cap
    xchg_en_reg #(.W(NARROW_W)) u_cap (
      .clk(clk), .rst(rst), .ld_n(cap_ld[i]), .d(cap_d[i]), .q(cap_q[i])
    );
  end

  // Select acts without a clock on the held words.
  always_comb a_out = sel ? cap_q[0] : cap_q[1];

  p_cap1_load_r6: assert property (@(posedge clk) disable iff (rst)
    !ld_b1_n |=> cap_q[0] == $past(b1_in));
  p_cap1_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ld_b1_n |=> $stable(cap_q[0]));
  p_cap2_load_r6: assert property (@(posedge clk) disable iff (rst)
    !ld_b2_n |=> cap_q[1] == $past(b2_in));
  p_cap2_hold_r6: assert property (@(posedge clk) disable iff (rst)
    ld_b2_n |=> $stable(cap_q[1]));
endmodule

// File: rtl/xchg_oe_sync.sv
module xchg_oe_sync
  import xchg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   oe_a_n,
  input  logic   oe_b_n,
  output drive_t drv
);
  always_ff @(posedge clk) begin
    if (rst) drv <= DRIVE_OFF;
    else     drv <= '{a_on: ~oe_a_n, b_on: ~oe_b_n};
  end

  p_a_sampled_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drv.a_on == !$past(oe_a_n));
  p_b_sampled_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drv.b_on == !$past(oe_b_n));
  p_both_off_r9: assert property (@(posedge clk) disable iff (rst)
    (oe_a_n && oe_b_n) |=> !drv.a_on && !drv.b_on);
  p_both_on_r9: assert property (@(posedge clk) disable iff (rst)
    (!oe_a_n && !oe_b_n) |=> drv.a_on && drv.b_on);
endmodule

// File: rtl/xchg_narrow_wide.sv
module xchg_narrow_wide
  import xchg_pkg::*;
#(
  parameter int NARROW_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NARROW_W-1:0] a_in,
  input  logic                ld_a1_n,
  input  logic                ld_a2_n,
  input  logic [NARROW_W-1:0] b1_in,
  input  logic [NARROW_W-1:0] b2_in,
  input  logic                ld_b1_n,
  input  logic                ld_b2_n,
  input  logic                sel,
  input  logic                oe_a_n,
  input  logic                oe_b_n,
  output logic [NARROW_W-1:0] a_out,
  output logic                a_drive,
  output logic [NARROW_W-1:0] b1_out,
  output logic [NARROW_W-1:0] b2_out,
  output logic                b_drive
);
  drive_t drv;

  xchg_a2b_path #(.NARROW_W(NARROW_W)) u_a2b (
    .clk(clk), .rst(rst), .a_in(a_in), .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n),
    .b1_out(b1_out), .b2_out(b2_out)
  );

  xchg_b2a_path #(.NARROW_W(NARROW_W)) u_b2a (
    .clk(clk), .rst(rst), .b1_in(b1_in), .b2_in(b2_in),
    .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n), .sel(sel), .a_out(a_out)
  );

  xchg_oe_sync u_oe (
    .clk(clk), .rst(rst), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .drv(drv)
  );

  assign a_drive = drv.a_on;
  assign b_drive = drv.b_on;
endmodule

// File: tb/tb_xchg_narrow_wide.sv
`timescale 1ns/1ps
module tb_xchg_narrow_wide;
  localparam int NW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic          ld_a1_n = 1'b1, ld_a2_n = 1'b1, ld_b1_n = 1'b1, ld_b2_n = 1'b1;
  logic          sel = 1'b0, oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic [NW-1:0] a_out, b1_out, b2_out;
  logic          a_drive, b_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xchg_narrow_wide #(.NARROW_W(NW)) dut (
    .clk(clk), .rst(rst), .a_in(a_in), .ld_a1_n(ld_a1_n), .ld_a2_n(ld_a2_n),
    .b1_in(b1_in), .b2_in(b2_in), .ld_b1_n(ld_b1_n), .ld_b2_n(ld_b2_n),
    .sel(sel), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .a_out(a_out), .a_drive(a_drive), .b1_out(b1_out), .b2_out(b2_out),
    .b_drive(b_drive)
  );

  // Row: {ld_a1_n, ld_a2_n, a_in, expected b1_out, expected b2_out}
  localparam int ROWS = 9;
  localparam logic [37:0] VEC [ROWS] = '{
    {1'b0, 1'b1, 12'h111, 12'h000, 12'h000},
    {1'b1, 1'b0, 12'h222, 12'h111, 12'h222},
    {1'b1, 1'b1, 12'h333, 12'h111, 12'h222},
    {1'b0, 1'b1, 12'hABC, 12'h111, 12'h222},
    {1'b1, 1'b1, 12'hFFF, 12'h111, 12'h222},
    {1'b1, 1'b0, 12'h5A5, 12'hABC, 12'h5A5},
    {1'b0, 1'b0, 12'h0F0, 12'hABC, 12'h0F0},
    {1'b0, 1'b0, 12'h777, 12'h0F0, 12'h777},
    {1'b1, 1'b0, 12'h123, 12'h777, 12'h123}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One rising edge, then settle at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    step();
    step();
    // R1: state after reset
    check("R1 b1_out", 32'(b1_out), 32'h0);
    check("R1 b2_out", 32'(b2_out), 32'h0);
    check("R1 a_out", 32'(a_out), 32'h0);
    check("R1 drives", {30'h0, a_drive, b_drive}, 32'h0);
    rst = 1'b0;

    // Narrow-to-wide vector walk
    for (int i = 0; i < ROWS; i++) begin
      {ld_a1_n, ld_a2_n, a_in} = VEC[i][37:24];
      step();
      if (i >= 6) begin
        check("R10 b1_out", 32'(b1_out), 32'(VEC[i][23:12]));
        check("R10 b2_out", 32'(b2_out), 32'(VEC[i][11:0]));
      end else if (i == 1 || i == 5) begin
        check("R5 b1_out", 32'(b1_out), 32'(VEC[i][23:12]));
        check("R5 b2_out", 32'(b2_out), 32'(VEC[i][11:0]));
      end else begin
        check("R2/R3 b1_out", 32'(b1_out), 32'(VEC[i][23:12]));
        check("R4 b2_out", 32'(b2_out), 32'(VEC[i][11:0]));
      end
    end
    ld_a1_n = 1'b1; ld_a2_n = 1'b1;

    // R6 and R7: capture both, then select
    b1_in = 12'h3C3; b2_in = 12'hC3C; ld_b1_n = 1'b0; ld_b2_n = 1'b0; sel = 1'b1;
    step();
    check("R7 sel=1", 32'(a_out), 32'h3C3);
    sel = 1'b0; #1;
    check("R7 sel=0 no edge", 32'(a_out), 32'hC3C);
    b1_in = 12'h001; b2_in = 12'h002; ld_b1_n = 1'b1; ld_b2_n = 1'b0;
    step();
    check("R6 2B loads", 32'(a_out), 32'h002);
    sel = 1'b1; #1;
    check("R6 1B holds", 32'(a_out), 32'h3C3);
    b1_in = 12'h400; b2_in = 12'h800; ld_b1_n = 1'b0; ld_b2_n = 1'b1;
    step();
    check("R6 1B loads", 32'(a_out), 32'h400);
    sel = 1'b0; #1;
    check("R6 2B holds", 32'(a_out), 32'h002);
    ld_b1_n = 1'b1;

    // R8 and R9: registered drive flags
    oe_a_n = 1'b0; oe_b_n = 1'b1; #1;
    check("R8 no change before edge", {30'h0, a_drive, b_drive}, 32'h0);
    step();
    check("R9 only A drives", {30'h0, a_drive, b_drive}, 32'h2);
    oe_b_n = 1'b0;
    step();
    check("R9 both drive", {30'h0, a_drive, b_drive}, 32'h3);
    oe_a_n = 1'b1; #1;
    check("R8 A held between edges", {30'h0, a_drive, b_drive}, 32'h3);
    step();
    check("R9 only B drives", {30'h0, a_drive, b_drive}, 32'h1);
    oe_b_n = 1'b1;
    step();
    check("R9 none drive", {30'h0, a_drive, b_drive}, 32'h0);

    // R1: reset mid-run clears loaded data and drive flags
    oe_a_n = 1'b0; oe_b_n = 1'b0;
    step();
    rst = 1'b1;
    step();
    check("R1 mid b1_out", 32'(b1_out), 32'h0);
    check("R1 mid b2_out", 32'(b2_out), 32'h0);
    check("R1 mid a_out", 32'(a_out), 32'h0);
    check("R1 mid drives", {30'h0, a_drive, b_drive}, 32'h0);
    rst = 1'b0;
    // R2: front register cleared by reset reaches b1_out as zero
    ld_a2_n = 1'b0; a_in = 12'h999;
    step();
    check("R2 front cleared", 32'(b1_out), 32'h0);
    check("R4 after reset", 32'(b2_out), 32'h999);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule